// File: doc/BRIEF.md
# Bank Pin-Event Interrupt Unit

This block watches the 32 input pins of one pin bank, grouped as four ports of eight pins, and turns chosen pin activity into a single bank interrupt. Each pin has its own trigger setting. It can fire on a rising transition, a falling transition or either transition. It can also fire while the pin sits at a high or a low level. A detected event sets a per-pin status bit. The bank interrupt output is high while any status bit has its enable bit set, in any port.

Software reaches the unit through a simple synchronous write port and a combinational read port. Each port has a status register, an enable register, a 24-bit trigger register and a write-one-to-clear register. The status, enable and trigger registers also have masked aliases. Through an alias, software can change individual pins without a read-modify-write sequence. Pin inputs pass through a synchronizer before detection.

Top module: `gpio_irq_bank`

## Requirements
- R1: For port p (0..3), the byte addresses are: status at 0x40+4p (read-only), enable at 0x50+4p, trigger at 0x60+4p and clear at 0x70+4p. Status and enable read back in bits 7:0 and the trigger word in bits 23:0. The clear register and any unmapped address read as zero.
- R2: While reset is high and on the first cycle after it, every enable register and every status register is zero and `irq_o` is low.
- R3: For pin n of a port, trigger bit 16+n selects both transitions, bit 8+n selects transition mode over level mode, and bit n is the polarity (1 = high or rising). In transition mode with bit 16+n clear, polarity 1 detects a 0 to 1 change and polarity 0 detects a 1 to 0 change. A pin change is visible in status three clock edges after it is applied: two synchronizer stages, then the comparison with the previous synchronized value.
- R4: With bits 16+n and 8+n set, both a 0 to 1 and a 1 to 0 change set the status bit. No change leaves it clear.
- R5: In level mode (bit 8+n clear), the status bit is set on every cycle that the synchronized pin equals the polarity bit. A clear therefore takes effect only after the pin has gone inactive.
- R6: Writing to the clear register clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R7: If a detection and a clear for the same pin fall in the same cycle, the status bit ends up set.
- R8: `irq_o` is high exactly when, in some port, a status bit and its enable bit are both 1.
- R9: A write to the masked enable alias at UPPER_OFS+0x50+4p uses data bits 15:8 as a pin mask and bits 7:0 as the new values. Only the masked enable bits change.
- R10: A write to the masked trigger alias at UPPER_OFS+0x60+4p uses data bits 31:24 as a pin mask. For each masked pin n, it loads bits n, 8+n and 16+n from data bits 23:0. The trigger bits of all other pins stay unchanged.
- R11: A write to the masked status alias at UPPER_OFS+0x40+4p sets or clears the masked status bits (mask in bits 15:8, values in bits 7:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous pin levels; pin 8p+n is bit n of port p |
| wr_en | input | 1 | Register write strobe, sampled at the clock edge |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_o | output | 1 | Bank interrupt |

## Verification
The hardest case to reach from the ports is a detection and a clear landing on the same pin in the same cycle. The pin is driven at a falling clock edge. The clear write is then placed exactly two falling edges later, so it is sampled at the same edge where the synchronized pin first differs from its previous value. A second hard case is a clear that does not stick while a level trigger stays active. For this, the pin is held high, the status is cleared and read back, and the sequence is repeated after the pin drops. A table of every trigger mode against several pin transitions covers the encoding.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PORTS   = 4;
    localparam int PORT_W  = 8;
    localparam int PINS    = PORTS * PORT_W;
    localparam int PSEL_W  = $clog2(PORTS);

    // Register kinds reachable through the bus
    typedef enum logic [2:0] {
        RK_NONE,
        RK_STAT,
        RK_EN,
        RK_TRIG,
        RK_CLR,
        RK_STAT_M,
        RK_EN_M,
        RK_TRIG_M
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e           kind;
        logic [PSEL_W-1:0]   port;
    } reg_sel_t;

    // Trigger word: three bit planes, one bit per pin in each plane
    typedef struct packed {
        logic [PORT_W-1:0] both;  // bits 23:16
        logic [PORT_W-1:0] edg;   // bits 15:8
        logic [PORT_W-1:0] pol;   // bits 7:0
    } trig_t;

    // Per-pin detection for one port
    function automatic logic [PORT_W-1:0] detect(trig_t t,
                                                 logic [PORT_W-1:0] cur,
                                                 logic [PORT_W-1:0] prev);
        logic [PORT_W-1:0] hit;
        for (int i = 0; i < PORT_W; i++) begin
            logic rise;
            logic fall;
            rise = cur[i] & ~prev[i];
            fall = ~cur[i] & prev[i];
            if (t.edg[i]) begin
                if (t.both[i]) hit[i] = rise | fall;
                else           hit[i] = t.pol[i] ? rise : fall;
            end else begin
                hit[i] = (cur[i] == t.pol[i]);
            end
        end
        return hit;
    endfunction

    // Address decode: plain window at 0x40..0x7F, masked window above upper
    function automatic reg_sel_t decode_addr(logic [31:0] a, logic [31:0] upper);
        reg_sel_t    r;
        logic        msk;
        logic [31:0] off;
        msk    = (a >= upper);
        off    = msk ? (a - upper) : a;
        r.kind = RK_NONE;
        r.port = off[2 +: PSEL_W];
        if (a[1:0] == 2'b00 && off >= 32'h40 && off < 32'h80) begin
            case (off[5:4])
                2'd0:    r.kind = msk ? RK_STAT_M : RK_STAT;
                2'd1:    r.kind = msk ? RK_EN_M   : RK_EN;
                2'd2:    r.kind = msk ? RK_TRIG_M : RK_TRIG;
                default: r.kind = msk ? RK_NONE   : RK_CLR;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
            prev_q <= '0;
        end else begin
            chain[0] <= raw_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
            prev_q <= chain[STAGES-1];
        end
    end

    assign cur_o  = chain[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] cur_i,
    input  logic [PORT_W-1:0] prev_i,
    input  logic [31:0]       wdata,
    input  logic              we_en,
    input  logic              we_en_m,
    input  logic              we_trig,
    input  logic              we_trig_m,
    input  logic              we_clr,
    input  logic              we_stat_m,
    output logic [PORT_W-1:0] status_o,
    output logic [PORT_W-1:0] enable_o,
    output trig_t             trig_o,
    output logic              irq_o
);
    localparam int TW = 3 * PORT_W;

    logic [PORT_W-1:0] status_q, en_q, hit, stat_base;
    logic [PORT_W-1:0] wmask, wval;
    logic [TW-1:0]     tmask;
    trig_t             trig_q;

    assign wmask = wdata[2*PORT_W-1:PORT_W];
    assign wval  = wdata[PORT_W-1:0];
    assign tmask = {3{wdata[31:32-PORT_W]}};
    assign hit   = detect(trig_q, cur_i, prev_i);

    always_comb begin
        stat_base = status_q;
        if (we_clr)    stat_base = stat_base & ~wval;
        if (we_stat_m) stat_base = (stat_base & ~wmask) | (wval & wmask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            en_q     <= '0;
            trig_q   <= '0;
        end else begin
            status_q <= stat_base | hit;
            if (we_en)        en_q <= wval;
            else if (we_en_m) en_q <= (en_q & ~wmask) | (wval & wmask);
            if (we_trig)        trig_q <= trig_t'(wdata[TW-1:0]);
            else if (we_trig_m) trig_q <= trig_t'((TW'(trig_q) & ~tmask) | (wdata[TW-1:0] & tmask));
        end
    end

    assign status_o = status_q;
    assign enable_o = en_q;
    assign trig_o   = trig_q;
    assign irq_o    = |(status_q & en_q);

    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
        we_clr |=> ((status_q & $past(wval & ~hit)) == '0));
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((status_q & $past(hit)) == $past(hit)));
    assert_rst_enable_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '0 && status_q == '0));
    assert_en_keep_R9: assert property (@(posedge clk) disable iff (rst)
        we_en_m |=> ((en_q & ~$past(wmask)) == ($past(en_q) & ~$past(wmask))));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter logic [31:0] UPPER_OFS   = 32'h80,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PINS-1:0]   pin_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq_o
);
    logic [PINS-1:0]   cur, prev;
    logic [PORTS-1:0]  port_irq;
    logic [PORT_W-1:0] st   [PORTS];
    logic [PORT_W-1:0] en   [PORTS];
    trig_t             tr   [PORTS];
    reg_sel_t          sel;

    assign sel = decode_addr(32'(addr), UPPER_OFS);

    gpio_irq_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i (pin_i),
        .cur_o (cur),
        .prev_o(prev)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic hit_port;
        assign hit_port = wr_en && (sel.port == PSEL_W'(p));
        gpio_irq_port u_port (
            .clk      (clk),
            .rst      (rst),
            .cur_i    (cur[p*PORT_W +: PORT_W]),
            .prev_i   (prev[p*PORT_W +: PORT_W]),
            .wdata    (wdata),
            .we_en    (hit_port && sel.kind == RK_EN),
            .we_en_m  (hit_port && sel.kind == RK_EN_M),
            .we_trig  (hit_port && sel.kind == RK_TRIG),
            .we_trig_m(hit_port && sel.kind == RK_TRIG_M),
            .we_clr   (hit_port && sel.kind == RK_CLR),
            .we_stat_m(hit_port && sel.kind == RK_STAT_M),
            .status_o (st[p]),
            .enable_o (en[p]),
            .trig_o   (tr[p]),
            .irq_o    (port_irq[p])
        );
    end

    always_comb begin
        rdata = '0;
        case (sel.kind)
            RK_STAT, RK_STAT_M: rdata = 32'(st[sel.port]);
            RK_EN, RK_EN_M:     rdata = 32'(en[sel.port]);
            RK_TRIG, RK_TRIG_M: rdata = 32'(tr[sel.port]);
            default:            rdata = '0;
        endcase
    end

    assign irq_o = |port_irq;

    logic any_en;
    always_comb begin
        any_en = 1'b0;
        for (int p = 0; p < PORTS; p++) any_en = any_en | (|en[p]);
    end

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> any_en);
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pin_i = '0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpio_irq_bank dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    // {both, edge, pol, v0, v1, expected}
    localparam logic [5:0] VEC [11] = '{
        6'b011_01_1, 6'b011_10_0,   // rising
        6'b010_01_0, 6'b010_10_1,   // falling
        6'b110_01_1, 6'b110_10_1, 6'b110_11_0, // both
        6'b001_01_1, 6'b001_00_0,   // level high
        6'b000_11_0, 6'b000_10_1    // level low
    };

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a falling edge; write sampled at the next rising edge
    task automatic wr(logic [11:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        @(negedge clk);
        @(negedge clk);
        // R2: state during reset
        rd(12'h40, d); check("R2 status in reset", d, 0);
        rd(12'h5C, d); check("R2 enable in reset", d, 0);
        check("R2 irq in reset", {31'b0, irq_o}, 0);
        rst = 1'b0;
        rd(12'h50, d); check("R2 enable after reset", d, 0);
        check("R2 irq after reset", {31'b0, irq_o}, 0);

        // R3 R4 R5: trigger table on pin 21 (port 2, bit 5)
        foreach (VEC[i]) begin
            logic [2:0] m;
            m = VEC[i][5:3];
            wr(12'hE8, {8'h20, m[2] ? 8'h20 : 8'h00, m[1] ? 8'h20 : 8'h00, m[0] ? 8'h20 : 8'h00});
            pin_i[21] = VEC[i][2];
            wait_n(5);
            wr(12'h78, 32'h20);
            pin_i[21] = VEC[i][1];
            wait_n(4);
            rd(12'h48, d);
            check($sformatf("R3 R4 R5 vector %0d", i), {31'b0, d[5]}, {31'b0, VEC[i][0]});
        end

        // R1: trigger register readback, clear reads zero
        wr(12'h6C, 32'h0012_3456);
        rd(12'h6C, d); check("R1 trigger readback", d, 32'h0012_3456);
        rd(12'h7C, d); check("R1 clear reads zero", d, 0);
        rd(12'h44 + 12'h1, d); check("R1 unaligned reads zero", d, 0);
        // R10: masked trigger
        wr(12'hEC, 32'h01FF_FFFF);
        rd(12'h6C, d); check("R10 masked trigger", d, 32'h0013_3557);

        // R9: masked enable
        wr(12'h54, 32'hA5);
        wr(12'hD4, 32'h0302);
        rd(12'h54, d); check("R9 masked enable", d, 32'hA6);
        wr(12'h54, 32'h0);

        // R8: port 0 level-low with pins low sets status; enabling raises irq
        wr(12'h50, 32'h01);
        wait_n(1);
        check("R8 irq from port 0", {31'b0, irq_o}, 1);
        wr(12'h50, 32'h00);
        check("R8 irq off when disabled", {31'b0, irq_o}, 0);

        // Port 3 all rising
        wr(12'h6C, 32'h0000_FFFF);
        wr(12'h7C, 32'hFF);
        wr(12'h5C, 32'h01);
        check("R8 irq low before event", {31'b0, irq_o}, 0);
        pin_i[24] = 1'b1;
        wait_n(4);
        check("R8 irq from port 3", {31'b0, irq_o}, 1);

        // R6: zero writes to clear do nothing; one clears
        wr(12'h7C, 32'h00);
        rd(12'h4C, d); check("R6 zero clear keeps status", d & 32'h1, 1);
        wr(12'h7C, 32'h01);
        rd(12'h4C, d); check("R6 one clears status", d & 32'h1, 0);
        check("R6 irq drops after clear", {31'b0, irq_o}, 0);

        // R7: set wins over same-cycle clear
        pin_i[24] = 1'b0;
        wait_n(4);
        wr(12'h7C, 32'h01);
        pin_i[24] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(12'h7C, 32'h01);
        rd(12'h4C, d); check("R7 set wins over clear", d & 32'h1, 1);
        wr(12'h7C, 32'h01);
        rd(12'h4C, d); check("R7 later clear sticks", d & 32'h1, 0);

        // R11: masked status write on port 3 bit 7
        wr(12'hCC, 32'h8080);
        rd(12'h4C, d); check("R11 masked status set", d & 32'h80, 32'h80);
        wr(12'hCC, 32'h8000);
        rd(12'h4C, d); check("R11 masked status clear", d & 32'h80, 0);

        // R5: level high on pin 8 holds status until the pin drops
        wr(12'h64, 32'h0000_0001);
        pin_i[8] = 1'b1;
        wait_n(4);
        wr(12'h74, 32'h01);
        wait_n(1);
        rd(12'h44, d); check("R5 level re-sets after clear", d & 32'h1, 1);
        pin_i[8] = 1'b0;
        wait_n(4);
        wr(12'h74, 32'h01);
        wait_n(1);
        rd(12'h44, d); check("R5 clear holds when inactive", d & 32'h1, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule